// File: doc/BRIEF.md
# Bus Master Security Filter

This block stands between one bus master and the downstream memory system and judges every read and write the master issues. For each request it looks at two flags from an external address attribution lookup and at two registered configuration bits. The flags are `exempt` and `non-secure`, and they apply to the address currently on the upstream port. The configuration bits say whether the master is non-secure and how blocked accesses are answered. The filter then forwards the access with the secure attribute set, forwards it with the attribute cleared, or blocks it.

A blocked access never reaches the downstream side. It ends in one of two ways, chosen by configuration. In the quiet way it completes with an OK response: a read returns zero and a write is dropped. In the loud way it completes with an error response and sets a sticky interrupt status. An interrupt-clear input clears that status, and while the clear is held high it also stops a blocked access from setting the status.

The request/response interface is simple. At most one transaction is outstanding, and the upstream side stalls while a forwarded access waits for its downstream response. Data is little-endian and passes through with no lane shifting. The size field encodes 1, 2, 4 or 8 bytes.

Top module: `bus_master_sec_filter`

## Requirements
- R1: Every accepted request resolves to exactly one outcome: forward as secure, forward as non-secure, block silently, or block with an error.
- R2: When `lkp_exempt` is high the access is forwarded, whatever the value of `lkp_nonsec`. `dn_secure` is the inverse of the registered master-non-secure bit.
- R3: When `lkp_exempt` is low and `lkp_nonsec` is high, the access is forwarded with `dn_secure` low, whatever the master configuration.
- R4: When both lookup flags are low and the master is configured secure, the access is forwarded with `dn_secure` high.
- R5: When both lookup flags are low and the master is configured non-secure, the access is blocked. No downstream request is issued, and the upstream response arrives one cycle after acceptance.
- R6: When a blocked access meets a low error-response configuration, it completes with `up_rsp_err` = 0 and `up_rsp_rdata` = 0.
- R7: When a blocked access meets a high error-response configuration, it completes with `up_rsp_err` = 1. It also sets the interrupt status unless the registered clear input is high.
- R8: The interrupt status is sticky: it stays high until cleared. The registered clear input forces it low. `irq` always shows the status.
- R9: After reset the configuration registers, the registered clear input and the interrupt status are all zero. `up_req_ready` is high and no valid signal is asserted.
- R10: A forwarded access passes address, size (0=1B, 1=2B, 2=4B, 3=8B), the write flag and write data to the downstream side unchanged, one cycle after acceptance. The downstream read data and error come back upstream unchanged, one cycle after `dn_rsp_valid`.
- R11: While a forwarded access is outstanding, `up_req_ready` is low and no further request is accepted.
- R12: The configuration and clear inputs are registered, so a change takes effect from the next clock edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master_ns | input | 1 | Master is non-secure (level) |
| cfg_err_resp | input | 1 | Blocked accesses answer with an error (level) |
| irq_clr | input | 1 | Interrupt clear (level) |
| irq | output | 1 | Interrupt level |
| lkp_exempt | input | 1 | Lookup: address is exempt from checking |
| lkp_nonsec | input | 1 | Lookup: address is non-secure |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Upstream request accepted when high |
| up_addr | input | ADDR_W | Upstream address |
| up_write | input | 1 | 1 = write, 0 = read |
| up_size | input | 2 | Access size code |
| up_wdata | input | DATA_W | Write data |
| up_rsp_valid | output | 1 | Upstream response valid |
| up_rsp_rdata | output | DATA_W | Read data |
| up_rsp_err | output | 1 | Error response |
| dn_req_valid | output | 1 | Downstream request valid (one cycle) |
| dn_addr | output | ADDR_W | Downstream address |
| dn_write | output | 1 | Downstream write flag |
| dn_size | output | 2 | Downstream size code |
| dn_wdata | output | DATA_W | Downstream write data |
| dn_secure | output | 1 | Downstream secure attribute |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_rdata | input | DATA_W | Downstream read data |
| dn_rsp_err | input | 1 | Downstream error response |

## Verification
The hardest case to reach is a blocked error access that lands while the registered clear is high. The interrupt must then stay low, although the same access would have raised it a cycle later. The stimulus raises the interrupt, holds the clear long enough for its registered copy to take effect, issues a blocked error access while the clear is held, and checks that the interrupt stays low. It then releases the clear and repeats the access to show that the interrupt now sets and stays set. Stalling is reached by keeping `up_req_valid` high with a new request while the downstream response is held back.

// File: rtl/sec_filter_pkg.sv
package sec_filter_pkg;
  typedef enum logic [1:0] {
    ACT_FWD_SEC  = 2'd0,
    ACT_FWD_NSEC = 2'd1,
    ACT_BLK_ZERO = 2'd2,
    ACT_BLK_ERR  = 2'd3
  } sf_action_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } sf_state_e;
endpackage

// File: rtl/sec_decide.sv
module sec_decide
  import sec_filter_pkg::*;
(
  input  logic       exempt,
  input  logic       nonsec,
  input  logic       master_ns,
  input  logic       err_resp,
  output sf_action_e act
);
  always_comb begin
    if (exempt)
      act = master_ns ? ACT_FWD_NSEC : ACT_FWD_SEC;
    else if (nonsec)
      act = ACT_FWD_NSEC;
    else if (!master_ns)
      act = ACT_FWD_SEC;
    else
      act = err_resp ? ACT_BLK_ERR : ACT_BLK_ZERO;
  end
endmodule

// File: rtl/sec_irq.sv
module sec_irq (
  input  logic clk,
  input  logic rst,
  input  logic clr_in,
  input  logic set_evt,
  output logic irq
);
  logic clr_q;
  logic status_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_q    <= 1'b0;
      status_q <= 1'b0;
    end else begin
      clr_q <= clr_in;
      if (clr_q)
        status_q <= 1'b0;
      else if (set_evt)
        status_q <= 1'b1;
    end
  end

  assign irq = status_q;

  // R8: the registered clear forces the status low
  a_r8_clear_holds: assert property (@(posedge clk) disable iff (rst)
    clr_q |=> !irq);
  // R8: the status is sticky while no clear is registered
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr_q) |=> irq);
  // R7: an error block with no clear sets the status
  a_r7_sets: assert property (@(posedge clk) disable iff (rst)
    (set_evt && !clr_q) |=> irq);
endmodule

// File: rtl/bus_master_sec_filter.sv
module bus_master_sec_filter
  import sec_filter_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_master_ns,
  input  logic              cfg_err_resp,
  input  logic              irq_clr,
  output logic              irq,
  input  logic              lkp_exempt,
  input  logic              lkp_nonsec,
  input  logic              up_req_valid,
  output logic              up_req_ready,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_write,
  input  logic [1:0]        up_size,
  input  logic [DATA_W-1:0] up_wdata,
  output logic              up_rsp_valid,
  output logic [DATA_W-1:0] up_rsp_rdata,
  output logic              up_rsp_err,
  output logic              dn_req_valid,
  output logic [ADDR_W-1:0] dn_addr,
  output logic              dn_write,
  output logic [1:0]        dn_size,
  output logic [DATA_W-1:0] dn_wdata,
  output logic              dn_secure,
  input  logic              dn_rsp_valid,
  input  logic [DATA_W-1:0] dn_rsp_rdata,
  input  logic              dn_rsp_err
);
  sf_state_e  state_q;
  logic       mns_q, errr_q;
  sf_action_e act;
  logic       accept, blk_err_evt;

  sec_decide u_decide (
    .exempt   (lkp_exempt),
    .nonsec   (lkp_nonsec),
    .master_ns(mns_q),
    .err_resp (errr_q),
    .act      (act)
  );

  assign up_req_ready = (state_q == ST_IDLE);
  assign accept       = up_req_valid && up_req_ready;
  assign blk_err_evt  = accept && (act == ACT_BLK_ERR);

  sec_irq u_irq (
    .clk    (clk),
    .rst    (rst),
    .clr_in (irq_clr),
    .set_evt(blk_err_evt),
    .irq    (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mns_q  <= 1'b0;
      errr_q <= 1'b0;
    end else begin
      mns_q  <= cfg_master_ns;
      errr_q <= cfg_err_resp;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      dn_req_valid <= 1'b0;
      dn_addr      <= '0;
      dn_write     <= 1'b0;
      dn_size      <= 2'd0;
      dn_wdata     <= '0;
      dn_secure    <= 1'b0;
      up_rsp_valid <= 1'b0;
      up_rsp_rdata <= '0;
      up_rsp_err   <= 1'b0;
    end else begin
      dn_req_valid <= 1'b0;
      up_rsp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (act == ACT_FWD_SEC || act == ACT_FWD_NSEC) begin
              dn_req_valid <= 1'b1;
              dn_addr      <= up_addr;
              dn_write     <= up_write;
              dn_size      <= up_size;
              dn_wdata     <= up_wdata;
              dn_secure    <= (act == ACT_FWD_SEC);
              state_q      <= ST_WAIT;
            end else begin
              up_rsp_valid <= 1'b1;
              up_rsp_rdata <= '0;
              up_rsp_err   <= (act == ACT_BLK_ERR);
            end
          end
        end
        default: begin
          if (dn_rsp_valid) begin
            up_rsp_valid <= 1'b1;
            up_rsp_rdata <= dn_rsp_rdata;
            up_rsp_err   <= dn_rsp_err;
            state_q      <= ST_IDLE;
          end
        end
      endcase
    end
  end

  // R5: a blocked request yields a response and no downstream request
  a_r5_block_local: assert property (@(posedge clk) disable iff (rst)
    (accept && (act == ACT_BLK_ZERO || act == ACT_BLK_ERR)) |=> (!dn_req_valid && up_rsp_valid));
  // R3: a non-secure region goes out as non-secure
  a_r3_ns_region: assert property (@(posedge clk) disable iff (rst)
    (accept && !lkp_exempt && lkp_nonsec) |=> (dn_req_valid && !dn_secure));
  // R10: the downstream error is returned upstream unchanged
  a_r10_err_pass: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && dn_rsp_valid) |=> (up_rsp_valid && up_rsp_err == $past(dn_rsp_err)));
  // R11: no acceptance while a downstream request is outstanding
  a_r11_single: assert property (@(posedge clk) disable iff (rst)
    dn_req_valid |-> !up_req_ready);
  // R1: a request produces at most one kind of completion
  a_r1_one_outcome: assert property (@(posedge clk) disable iff (rst)
    !(dn_req_valid && up_rsp_valid));
endmodule

// File: tb/bus_master_sec_filter_test.sv
module bus_master_sec_filter_test;
  localparam int AW = 32;
  localparam int DW = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_master_ns = 0, cfg_err_resp = 0, irq_clr = 0, irq;
  logic lkp_exempt = 0, lkp_nonsec = 0;
  logic up_req_valid = 0, up_req_ready, up_write = 0;
  logic [AW-1:0] up_addr = '0;
  logic [1:0] up_size = 2'd0;
  logic [DW-1:0] up_wdata = '0;
  logic up_rsp_valid, up_rsp_err;
  logic [DW-1:0] up_rsp_rdata;
  logic dn_req_valid, dn_write, dn_secure;
  logic [AW-1:0] dn_addr;
  logic [1:0] dn_size;
  logic [DW-1:0] dn_wdata;
  logic dn_rsp_valid = 0, dn_rsp_err = 0;
  logic [DW-1:0] dn_rsp_rdata = '0;

  int checks = 0, fails = 0;
  bit m_mns = 0, m_err = 0, m_clr = 0, m_irq = 0;

  always #5 clk = ~clk;

  bus_master_sec_filter #(.ADDR_W(AW), .DATA_W(DW)) uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // 0 fwd secure, 1 fwd non-secure, 2 block zero, 3 block error
  function automatic int exp_act(input bit ex, input bit ns, input bit mns, input bit er);
    if (ex) return mns ? 1 : 0;
    if (ns) return 1;
    if (!mns) return 0;
    return er ? 3 : 2;
  endfunction

  task automatic set_cfg(input bit mns, input bit er, input bit clr);
    @(negedge clk);
    cfg_master_ns = mns; cfg_err_resp = er; irq_clr = clr;
    @(negedge clk); @(negedge clk);
    m_mns = mns; m_err = er; m_clr = clr;
    if (clr) m_irq = 0;
    chk(irq == m_irq, "R8 irq after config", {63'd0, irq}, {63'd0, m_irq});
  endtask

  task automatic access(input logic [AW-1:0] a, input bit wr, input logic [DW-1:0] wd,
                        input logic [1:0] sz, input bit ex, input bit ns, input bit stall);
    int e;
    logic [DW-1:0] rd;
    bit re;
    e = exp_act(ex, ns, m_mns, m_err);
    @(negedge clk);
    up_req_valid = 1; up_addr = a; up_write = wr; up_wdata = wd; up_size = sz;
    lkp_exempt = ex; lkp_nonsec = ns;
    @(negedge clk);
    up_req_valid = 0;
    if (e <= 1) begin
      chk(dn_req_valid == 1'b1, "R1 forward issued", {63'd0, dn_req_valid}, 64'd1);
      chk(dn_secure == (e == 0), e == 0 ? "R4/R2 secure attr" : "R3/R2 non-secure attr",
          {63'd0, dn_secure}, {63'd0, (e == 0)});
      chk(dn_addr == a && dn_size == sz && dn_write == wr && dn_wdata == wd,
          "R10 request pass-through", {dn_addr, 30'd0, dn_size}, {a, 30'd0, sz});
      chk(up_req_ready == 1'b0, "R11 stall while outstanding", {63'd0, up_req_ready}, 64'd0);
      if (stall) begin
        up_req_valid = 1; up_addr = ~a;
        repeat (2) begin
          @(negedge clk);
          chk(up_req_ready == 0 && !dn_req_valid && !up_rsp_valid, "R11 held request ignored",
              {62'd0, up_req_ready, dn_req_valid}, 64'd0);
        end
        up_req_valid = 0;
      end else begin
        repeat ($urandom_range(0, 2)) @(negedge clk);
      end
      rd = {$urandom, $urandom}; re = 1'($urandom_range(0, 1));
      dn_rsp_valid = 1; dn_rsp_rdata = rd; dn_rsp_err = re;
      @(negedge clk);
      dn_rsp_valid = 0;
      chk(up_rsp_valid && up_rsp_rdata == rd && up_rsp_err == re, "R10 response pass-through",
          up_rsp_rdata, rd);
    end else begin
      chk(dn_req_valid == 0, "R5 no downstream request", {63'd0, dn_req_valid}, 64'd0);
      chk(up_rsp_valid == 1, "R5 local response", {63'd0, up_rsp_valid}, 64'd1);
      if (e == 2)
        chk(up_rsp_err == 0 && up_rsp_rdata == 0, "R6 silent block", up_rsp_rdata, 64'd0);
      else
        chk(up_rsp_err == 1, "R7 error block", {63'd0, up_rsp_err}, 64'd1);
      if (e == 3 && !m_clr) m_irq = 1;
    end
    chk(irq == m_irq, "R7/R8 irq level", {63'd0, irq}, {63'd0, m_irq});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    chk(irq == 0 && up_req_ready && !up_rsp_valid && !dn_req_valid, "R9 reset state",
        {60'd0, irq, up_req_ready, up_rsp_valid, dn_req_valid}, 64'h4);
    // Directed: R2 exempt priority, secure master
    access(32'h100, 0, '0, 2'd3, 1, 1, 0);
    // R4 secure region, secure master
    access(32'h200, 1, 64'h0123_4567_89ab_cdef, 2'd2, 0, 0, 0);
    // R12: raise master_ns but probe before it registers
    @(negedge clk);
    cfg_master_ns = 1;
    up_req_valid = 1; up_addr = 32'h300; up_write = 0; lkp_exempt = 0; lkp_nonsec = 0;
    @(negedge clk);
    up_req_valid = 0;
    chk(dn_req_valid && dn_secure, "R12 old config used on same edge", {62'd0, dn_req_valid, dn_secure}, 64'd3);
    dn_rsp_valid = 1; @(negedge clk); dn_rsp_valid = 0;
    m_mns = 1;
    @(negedge clk);
    // R2 exempt with non-secure master, R3, R6
    access(32'h400, 0, '0, 2'd0, 1, 0, 0);
    access(32'h500, 1, 64'hff, 2'd1, 0, 1, 1);
    access(32'h600, 0, '0, 2'd3, 0, 0, 0);
    access(32'h604, 1, 64'h55, 2'd3, 0, 0, 0);
    // R7 error block sets irq, R8 sticky
    set_cfg(1, 1, 0);
    access(32'h700, 0, '0, 2'd2, 0, 0, 0);
    access(32'h800, 0, '0, 2'd2, 0, 1, 0);
    // R8 held clear: clears and suppresses
    set_cfg(1, 1, 1);
    access(32'h704, 1, 64'h1, 2'd0, 0, 0, 0);
    set_cfg(1, 1, 0);
    access(32'h708, 1, 64'h2, 2'd0, 0, 0, 0);
    // Random mix
    for (int i = 0; i < 300; i++) begin
      if (i % 12 == 0)
        set_cfg(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), ($urandom_range(0, 5) == 0));
      access($urandom, 1'($urandom_range(0, 1)), {$urandom, $urandom}, 2'($urandom_range(0, 3)),
             ($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)), ($urandom_range(0, 9) == 0));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule